// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge/Completion Handshake

This block gathers a parameterized number of raw interrupt lines (128 by default) and presents one interrupt request to a single processor. Each source carries its own enable bit, an 8-bit priority, an 8-bit target byte and a 2-bit configuration field. A source is latched as pending either by its level while the line is high or by a rising edge. Among the sources that are enabled, pending, not already in service and more urgent than a global threshold, the controller picks one winner. A lower priority value is more urgent, and equal values are broken toward the lower ID.

Software drives it through a 32-bit word-addressed register bus with a 13-bit byte address. Address bit 12 clear selects the processor-side registers: control, threshold, acknowledge and completion. Address bit 12 set selects the per-source tables. Reading the acknowledge register returns the winner's ID and moves that source into service. Writing the ID to the completion register ends service. The ID 1023 means nothing qualifies. The request output is registered and stays high for as long as a qualifying winner exists.

Top module: `intc_top`

## Requirements
- R1: After reset, `irq_out` is low and every register reads 0, except the acknowledge register at 0x000C, which reads 1023.
- R2: Enable bits are set through the word at 0x1100+4*(N/32) and cleared through the word at 0x1180+4*(N/32), with source N at bit N%32. In each word a 1 acts and a 0 has no effect, and both words read back the current enable bitmap. A disabled source is never signalled.
- R3: The priority of source N is byte lane N%4 of the word at 0x1400+4*(N/4). Its target byte occupies the same lane at 0x1800+4*(N/4). Both read back as written.
- R4: Source N has a 2-bit field at bits [2*(N%16)+1 : 2*(N%16)] of the word at 0x1C00+4*(N/16), and the field reads back as written. Its upper bit selects rising-edge sensing (1) or level-high sensing (0). Its lower bit is stored only and has no effect on behaviour.
- R5: A level source is pending while its line is high. `irq_out` rises on the second rising clock edge after the line is asserted.
- R6: On an edge source, a rising edge latches pending, which survives the line falling. An acknowledge clears the latched pending. A line held high does not pend again, and an edge arriving while the source is in service is remembered.
- R7: A source is forwarded only when its priority value is strictly below the threshold in bits [7:0] of 0x0004.
- R8: The winner is the qualifying source with the lowest priority value, and a tie goes to the lowest ID.
- R9: A read of 0x000C returns the winner's ID in bits [9:0] and puts that source in service. A source in service is not signalled again.
- R10: Writing an ID to 0x0010 ends its service. A level source whose line is still high becomes pending and is signalled again.
- R11: The acknowledge read returns 1023 and `irq_out` stays low when nothing qualifies, or when either of the two control bits is clear: bit 0 of 0x0000 (processor side) or bit 0 of 0x1000 (distributor).
- R12: `irq_out` is registered. It follows the presence of a qualifying winner one clock later and falls on the second edge after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source ID |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (the acknowledge read has a side effect) |
| bus_addr | input | 13 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench sweeps every enable, priority, target and configuration word with computed patterns. It then drains all sources raised at once and checks the acknowledge order against a minimum search done in the bench, so a design that compared with `<=` or scanned from the top ID would hand out ties in the wrong order. It steps the threshold exactly at and one above each source's priority, which catches an off-by-one compare that forwards at equality. It also pulses, holds and re-pulses an edge source across acknowledge and completion: a design that treated edge sources as level would re-signal a held line, and one that dropped edges seen during service would lose the second event. Sampling `irq_out` on exact cycles catches a request wired combinationally or delayed by an extra register.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 13;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // processor-side word offsets (address bit 12 clear)
  localparam logic [11:0] OFF_CPU_CTRL = 12'h000;
  localparam logic [11:0] OFF_PMASK    = 12'h004;
  localparam logic [11:0] OFF_ACK      = 12'h00C;
  localparam logic [11:0] OFF_EOI      = 12'h010;
  // distributor-side offsets (address bit 12 set)
  localparam logic [11:0] OFF_DIST_CTRL = 12'h000;
  localparam logic [4:0]  SEG_SET_EN    = 5'b00010; // 0x100..0x17F
  localparam logic [4:0]  SEG_CLR_EN    = 5'b00011; // 0x180..0x1FF
  localparam logic [1:0]  SEG_PRIO      = 2'b01;    // 0x400..0x7FF
  localparam logic [1:0]  SEG_TGT       = 2'b10;    // 0x800..0xBFF
  localparam logic [1:0]  SEG_CFG       = 2'b11;    // 0xC00..
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic                            deliver,
  input  logic [ID_W-1:0]                 deliver_id,
  output logic                            cpu_en,
  output logic                            dist_en,
  output logic [PRIO_W-1:0]               pmask,
  output logic [NUM_SRC-1:0]              src_en,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  src_prio,
  output logic [NUM_SRC-1:0]              src_edge,
  output logic                            ack_fire,
  output logic                            eoi_fire,
  output logic [ID_W-1:0]                 eoi_id
);
  localparam int EN_WORDS = NUM_SRC / 32;

  logic        aligned, is_dist, acc_wr, acc_rd;
  logic [11:0] off;
  logic [4:0]  en_idx;
  logic [7:0]  grp_idx;
  logic hit_cpu_ctrl, hit_pmask, hit_ack, hit_eoi, hit_dist_ctrl;
  logic in_set, in_clr, in_prio, in_tgt, in_cfg;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign is_dist = bus_addr[12];
  assign off     = bus_addr[11:0];
  assign en_idx  = off[6:2];
  assign grp_idx = off[9:2];
  assign acc_wr  = bus_sel & bus_wr & aligned;
  assign acc_rd  = bus_sel & bus_rd & aligned;

  assign hit_cpu_ctrl  = !is_dist && (off == OFF_CPU_CTRL);
  assign hit_pmask     = !is_dist && (off == OFF_PMASK);
  assign hit_ack       = !is_dist && (off == OFF_ACK);
  assign hit_eoi       = !is_dist && (off == OFF_EOI);
  assign hit_dist_ctrl =  is_dist && (off == OFF_DIST_CTRL);
  assign in_set  = is_dist && (off[11:7] == SEG_SET_EN);
  assign in_clr  = is_dist && (off[11:7] == SEG_CLR_EN);
  assign in_prio = is_dist && (off[11:10] == SEG_PRIO);
  assign in_tgt  = is_dist && (off[11:10] == SEG_TGT);
  assign in_cfg  = is_dist && (off[11:10] == SEG_CFG);

  // state
  logic                           cpu_en_q, cpu_en_d, dist_en_q, dist_en_d;
  logic [PRIO_W-1:0]              pmask_q, pmask_d;
  logic [NUM_SRC-1:0]             en_q, en_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_SRC-1:0][7:0]        tgt_q, tgt_d;
  logic [NUM_SRC-1:0][1:0]        cfg_q, cfg_d;

  // next-state
  always_comb begin
    cpu_en_d  = cpu_en_q;
    dist_en_d = dist_en_q;
    pmask_d   = pmask_q;
    en_d      = en_q;
    prio_d    = prio_q;
    tgt_d     = tgt_q;
    cfg_d     = cfg_q;
    if (hit_cpu_ctrl)  cpu_en_d  = bus_wdata[0];
    if (hit_dist_ctrl) dist_en_d = bus_wdata[0];
    if (hit_pmask)     pmask_d   = bus_wdata[PRIO_W-1:0];
    for (int w = 0; w < EN_WORDS; w++) begin
      if (in_set && int'(en_idx) == w) en_d[w*32 +: 32] = en_q[w*32 +: 32] | bus_wdata;
      if (in_clr && int'(en_idx) == w) en_d[w*32 +: 32] = en_q[w*32 +: 32] & ~bus_wdata;
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (in_prio && int'(grp_idx) == s / 4)  prio_d[s] = bus_wdata[8*(s%4) +: 8];
      if (in_tgt  && int'(grp_idx) == s / 4)  tgt_d[s]  = bus_wdata[8*(s%4) +: 8];
      if (in_cfg  && int'(grp_idx) == s / 16) cfg_d[s]  = bus_wdata[2*(s%16) +: 2];
    end
  end

  // registers, clock-enabled by a bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q  <= 1'b0;
      dist_en_q <= 1'b0;
      pmask_q   <= '0;
      en_q      <= '0;
      prio_q    <= '0;
      tgt_q     <= '0;
      cfg_q     <= '0;
    end else if (acc_wr) begin
      cpu_en_q  <= cpu_en_d;
      dist_en_q <= dist_en_d;
      pmask_q   <= pmask_d;
      en_q      <= en_d;
      prio_q    <= prio_d;
      tgt_q     <= tgt_d;
      cfg_q     <= cfg_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_cpu_ctrl)  bus_rdata[0] = cpu_en_q;
    if (hit_pmask)     bus_rdata[PRIO_W-1:0] = pmask_q;
    if (hit_ack)       bus_rdata[ID_W-1:0] = deliver ? deliver_id : SPURIOUS_ID;
    if (hit_dist_ctrl) bus_rdata[0] = dist_en_q;
    for (int w = 0; w < EN_WORDS; w++)
      if ((in_set || in_clr) && int'(en_idx) == w) bus_rdata = en_q[w*32 +: 32];
    for (int s = 0; s < NUM_SRC; s++) begin
      if (in_prio && int'(grp_idx) == s / 4)  bus_rdata[8*(s%4) +: 8] = prio_q[s];
      if (in_tgt  && int'(grp_idx) == s / 4)  bus_rdata[8*(s%4) +: 8] = tgt_q[s];
      if (in_cfg  && int'(grp_idx) == s / 16) bus_rdata[2*(s%16) +: 2] = cfg_q[s];
    end
  end

  assign cpu_en   = cpu_en_q;
  assign dist_en  = dist_en_q;
  assign pmask    = pmask_q;
  assign src_en   = en_q;
  assign src_prio = prio_q;
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
      assign src_edge[i] = cfg_q[i][1];
    end
  endgenerate

  assign ack_fire = acc_rd & hit_ack & deliver;
  assign eoi_fire = acc_wr & hit_eoi;
  assign eoi_id   = bus_wdata[ID_W-1:0];
endmodule

// File: rtl/intc_track.sv
module intc_track
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] src_edge,
  input  logic               ack_fire,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               eoi_fire,
  input  logic [ID_W-1:0]    eoi_id,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] act
);
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic line_q, pend_q, act_q;
      logic ack_hit, eoi_hit, rise, pend_d, act_d;

      assign ack_hit = ack_fire && (ack_id == ID_W'(i));
      assign eoi_hit = eoi_fire && (eoi_id == ID_W'(i));
      assign rise    = irq_in[i] & ~line_q;

      always_comb begin
        if (src_edge[i]) pend_d = (pend_q & ~ack_hit) | rise;
        else             pend_d = irq_in[i];
        act_d = (act_q | ack_hit) & ~eoi_hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          line_q <= 1'b0;
          pend_q <= 1'b0;
          act_q  <= 1'b0;
        end else begin
          line_q <= irq_in[i];
          pend_q <= pend_d;
          if (ack_hit || eoi_hit) act_q <= act_d;
        end
      end

      assign pend[i] = pend_q;
      assign act[i]  = act_q;
    end
  endgenerate
endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0]             act,
  input  logic [NUM_SRC-1:0]             src_en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]              pmask,
  output logic                           found,
  output logic [ID_W-1:0]                win_id
);
  logic [NUM_SRC-1:0] qual;
  logic [PRIO_W-1:0]  best;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
      assign qual[i] = pend[i] & ~act[i] & src_en[i] & (src_prio[i] < pmask);
    end
  endgenerate

  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    found  = 1'b0;
    best   = '1;
    win_id = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (!found || src_prio[i] < best)) begin
        found  = 1'b1;
        best   = src_prio[i];
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  // asynchronous assert, synchronous release
  logic rst_meta_n, rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_ok_n   <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_ok_n   <= rst_meta_n;
    end
  end

  logic                           cpu_en, dist_en, found, deliver;
  logic                           ack_fire, eoi_fire;
  logic [ID_W-1:0]                win_id, eoi_id;
  logic [PRIO_W-1:0]              pmask;
  logic [NUM_SRC-1:0]             src_en, src_edge, pend, act;
  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;

  assign deliver = cpu_en & dist_en & found;

  intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_ok_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .deliver(deliver), .deliver_id(win_id),
    .cpu_en(cpu_en), .dist_en(dist_en), .pmask(pmask),
    .src_en(src_en), .src_prio(src_prio), .src_edge(src_edge),
    .ack_fire(ack_fire), .eoi_fire(eoi_fire), .eoi_id(eoi_id)
  );

  intc_track #(.NUM_SRC(NUM_SRC)) u_track (
    .clk(clk), .rst_n(rst_ok_n),
    .irq_in(irq_in), .src_edge(src_edge),
    .ack_fire(ack_fire), .ack_id(win_id),
    .eoi_fire(eoi_fire), .eoi_id(eoi_id),
    .pend(pend), .act(act)
  );

  intc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend(pend), .act(act), .src_en(src_en), .src_prio(src_prio),
    .pmask(pmask), .found(found), .win_id(win_id)
  );

  logic irq_q;
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) irq_q <= 1'b0;
    else           irq_q <= deliver;
  end
  assign irq_out = irq_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input logic                           clk,
  input logic                           rst_ok_n,
  input logic                           cpu_en,
  input logic                           dist_en,
  input logic                           deliver,
  input logic [ID_W-1:0]                win_id,
  input logic [NUM_SRC-1:0]             pend,
  input logic [NUM_SRC-1:0]             act,
  input logic [NUM_SRC-1:0]             src_en,
  input logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
  input logic [PRIO_W-1:0]              pmask,
  input logic                           ack_fire,
  input logic                           eoi_fire,
  input logic [ID_W-1:0]                eoi_id,
  input logic                           irq_out,
  input logic                           bus_sel,
  input logic                           bus_rd,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [31:0]                    bus_rdata
);
  localparam int SRC_W = $clog2(NUM_SRC);
  logic [SRC_W-1:0] w;
  logic             ack_read;
  assign w        = win_id[SRC_W-1:0];
  assign ack_read = bus_sel && bus_rd && (bus_addr == 13'h000C);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(cpu_en && dist_en) |=> !irq_out);  // R11
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    deliver |=> irq_out);  // R12
  AST_WIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_ok_n)
    deliver |-> (win_id < ID_W'(NUM_SRC)) && pend[w] && !act[w] && src_en[w] && (src_prio[w] < pmask));  // R7
  AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ack_fire |=> act[$past(w)]);  // R9
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (eoi_fire && eoi_id < ID_W'(NUM_SRC)) |=> !act[$past(eoi_id[SRC_W-1:0])]);  // R10
  AST_SPURIOUS_ID: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ack_read && !deliver) |-> (bus_rdata == 32'd1023));  // R11
endmodule

bind intc_top intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_ok_n(rst_ok_n), .cpu_en(cpu_en), .dist_en(dist_en),
  .deliver(deliver), .win_id(win_id), .pend(pend), .act(act),
  .src_en(src_en), .src_prio(src_prio), .pmask(pmask),
  .ack_fire(ack_fire), .eoi_fire(eoi_fire), .eoi_id(eoi_id),
  .irq_out(irq_out), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
  localparam int N = 64;
  localparam logic [31:0] SPUR = 32'd1023;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          bus_sel, bus_wr, bus_rd;
  logic [12:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          irq_out;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  intc_top #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat_prio(input int n); return 8'(n * 37 + 5); endfunction
  function automatic logic [7:0] pat_tgt(input int n);  return 8'(n * 11) ^ 8'h5A; endfunction
  function automatic logic [1:0] pat_cfg(input int n);  return 2'(n * 3); endfunction
  function automatic logic [7:0] arb_prio(input int n); return 8'(((n * 3) % 7) * 10); endfunction

  task automatic load_arb_prio();
    for (int k = 0; k < N / 4; k++)
      bus_write(13'(32'h1400 + 4 * k), {arb_prio(4*k+3), arb_prio(4*k+2), arb_prio(4*k+1), arb_prio(4*k)});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] exp_en;
    logic [N-1:0] served;
    rst_n = 1'b0; irq_in = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 0);
    bus_read(13'h0000, d); chk("R1 cpu ctrl", d, 0);
    bus_read(13'h0004, d); chk("R1 threshold", d, 0);
    bus_read(13'h1000, d); chk("R1 dist ctrl", d, 0);
    bus_read(13'h1100, d); chk("R1 enables", d, 0);
    bus_read(13'h1400, d); chk("R1 priority", d, 0);
    bus_read(13'h1C00, d); chk("R1 config", d, 0);
    bus_read(13'h000C, d); chk("R1 ack spurious", d, SPUR);

    // R2 enable set/clear sweep
    exp_en = '0;
    for (int n = 0; n < N; n++) begin
      bus_write(13'(32'h1100 + 4 * (n / 32)), 32'(1) << (n % 32));
      exp_en[n] = 1'b1;
      bus_write(13'(32'h1100 + 4 * (n / 32)), 32'h0);
      bus_read(13'(32'h1100 + 4 * (n / 32)), d); chk("R2 set view", d, exp_en[(n/32)*32 +: 32]);
      bus_read(13'(32'h1180 + 4 * (n / 32)), d); chk("R2 clear view", d, exp_en[(n/32)*32 +: 32]);
    end
    for (int n = 1; n < N; n += 2) begin
      bus_write(13'(32'h1180 + 4 * (n / 32)), 32'(1) << (n % 32));
      exp_en[n] = 1'b0;
      bus_write(13'(32'h1180 + 4 * (n / 32)), 32'h0);
      bus_read(13'(32'h1100 + 4 * (n / 32)), d); chk("R2 after clear", d, exp_en[(n/32)*32 +: 32]);
    end
    for (int w = 0; w < N / 32; w++) bus_write(13'(32'h1100 + 4 * w), 32'hFFFF_FFFF);

    // R3 priority and target tables
    for (int k = 0; k < N / 4; k++) begin
      bus_write(13'(32'h1400 + 4 * k), {pat_prio(4*k+3), pat_prio(4*k+2), pat_prio(4*k+1), pat_prio(4*k)});
      bus_write(13'(32'h1800 + 4 * k), {pat_tgt(4*k+3), pat_tgt(4*k+2), pat_tgt(4*k+1), pat_tgt(4*k)});
    end
    for (int k = 0; k < N / 4; k++) begin
      bus_read(13'(32'h1400 + 4 * k), d);
      chk("R3 priority", d, {pat_prio(4*k+3), pat_prio(4*k+2), pat_prio(4*k+1), pat_prio(4*k)});
      bus_read(13'(32'h1800 + 4 * k), d);
      chk("R3 target", d, {pat_tgt(4*k+3), pat_tgt(4*k+2), pat_tgt(4*k+1), pat_tgt(4*k)});
    end

    // R4 configuration fields
    for (int k = 0; k < N / 16; k++) begin
      logic [31:0] v;
      for (int j = 0; j < 16; j++) v[2*j +: 2] = pat_cfg(16*k + j);
      bus_write(13'(32'h1C00 + 4 * k), v);
    end
    for (int k = 0; k < N / 16; k++) begin
      logic [31:0] v;
      for (int j = 0; j < 16; j++) v[2*j +: 2] = pat_cfg(16*k + j);
      bus_read(13'(32'h1C00 + 4 * k), d); chk("R4 config", d, v);
    end
    for (int k = 0; k < N / 16; k++) bus_write(13'(32'h1C00 + 4 * k), 32'h0);

    // functional setup
    load_arb_prio();
    bus_write(13'h1000, 32'h1);
    bus_write(13'h0000, 32'h1);
    bus_write(13'h0004, 32'hFF);

    // R5 / R12 / R9 / R10 on a level source
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); chk("R5 irq one edge", 32'(irq_out), 0);
    @(negedge clk); chk("R5 irq two edges", 32'(irq_out), 1);
    bus_read(13'h000C, d); chk("R9 ack id", d, 5);
    chk("R12 irq held one edge", 32'(irq_out), 1);
    @(negedge clk); chk("R12 irq drops", 32'(irq_out), 0);
    bus_read(13'h000C, d); chk("R9 active not resignalled", d, SPUR);
    bus_write(13'h0010, 32'd5);
    wait_n(2); chk("R10 level resignal irq", 32'(irq_out), 1);
    bus_read(13'h000C, d); chk("R10 level resignal id", d, 5);
    irq_in[5] = 1'b0;
    bus_write(13'h0010, 32'd5);
    wait_n(3);
    chk("R11 idle irq", 32'(irq_out), 0);
    bus_read(13'h000C, d); chk("R11 idle ack", d, SPUR);

    // R8 pairwise arbitration
    for (int a = 0; a < 12; a++) begin
      for (int b = a + 1; b < 12; b++) begin
        int e;
        e = (arb_prio(a) <= arb_prio(b)) ? a : b;
        @(negedge clk); irq_in[a] = 1'b1; irq_in[b] = 1'b1;
        wait_n(2);
        bus_read(13'h000C, d); chk("R8 pair winner", d, 32'(e));
        irq_in = '0;
        bus_write(13'h0010, 32'(e));
        wait_n(1);
      end
    end

    // R8 drain order with every line raised
    served = '0;
    @(negedge clk); irq_in = '1;
    wait_n(2);
    for (int step = 0; step < N; step++) begin
      int e;
      e = -1;
      for (int n = 0; n < N; n++)
        if (!served[n] && (e < 0 || arb_prio(n) < arb_prio(e))) e = n;
      bus_read(13'h000C, d); chk("R8 drain order", d, 32'(e));
      irq_in[e] = 1'b0;
      served[e] = 1'b1;
      bus_write(13'h0010, 32'(e));
    end
    wait_n(2);
    bus_read(13'h000C, d); chk("R8 drained", d, SPUR);

    // R7 threshold at and just above each priority
    for (int s = 0; s < 16; s++) begin
      @(negedge clk); irq_in[s] = 1'b1;
      for (int m = 0; m < 2; m++) begin
        logic [7:0] mk;
        logic       fwd;
        mk  = arb_prio(s) + 8'(m);
        fwd = (arb_prio(s) < mk);
        bus_write(13'h0004, 32'(mk));
        wait_n(2);
        chk("R7 irq vs threshold", 32'(irq_out), 32'(fwd));
        bus_read(13'h000C, d); chk("R7 ack vs threshold", d, fwd ? 32'(s) : SPUR);
        if (fwd) bus_write(13'h0010, 32'(s));
      end
      irq_in[s] = 1'b0;
      wait_n(2);
    end
    bus_write(13'h0004, 32'hFF);
    wait_n(2);

    // R6 edge source 40: config word 2, bit 17
    bus_write(13'h1C08, 32'h1 << 17);
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk); irq_in[40] = 1'b0;
    wait_n(3);
    chk("R6 latched irq", 32'(irq_out), 1);
    bus_read(13'h000C, d); chk("R6 latched ack", d, 40);
    bus_read(13'h000C, d); chk("R6 pending cleared", d, SPUR);
    bus_write(13'h0010, 32'd40);
    wait_n(2);
    bus_read(13'h000C, d); chk("R6 no repend after eoi", d, SPUR);
    @(negedge clk); irq_in[40] = 1'b1;
    wait_n(2);
    bus_read(13'h000C, d); chk("R6 held ack", d, 40);
    bus_write(13'h0010, 32'd40);
    wait_n(3);
    chk("R6 held no irq", 32'(irq_out), 0);
    bus_read(13'h000C, d); chk("R6 held no repend", d, SPUR);
    @(negedge clk); irq_in[40] = 1'b0;
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk); irq_in[40] = 1'b0;
    wait_n(2);
    bus_read(13'h000C, d); chk("R6 first event", d, 40);
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk); irq_in[40] = 1'b0;
    wait_n(2);
    bus_read(13'h000C, d); chk("R6 in service", d, SPUR);
    bus_write(13'h0010, 32'd40);
    wait_n(2);
    bus_read(13'h000C, d); chk("R6 remembered edge", d, 40);
    bus_write(13'h0010, 32'd40);
    wait_n(2);

    // R2 / R11 / R4 gating on source 7, lower config bit set (word 0, bit 14)
    bus_write(13'h1C00, 32'h1 << 14);
    bus_write(13'h1180, 32'h1 << 7);
    @(negedge clk); irq_in[7] = 1'b1;
    wait_n(3);
    chk("R2 disabled irq", 32'(irq_out), 0);
    bus_read(13'h000C, d); chk("R2 disabled ack", d, SPUR);
    bus_write(13'h1100, 32'h1 << 7);
    wait_n(2);
    chk("R2 enabled irq", 32'(irq_out), 1);
    bus_write(13'h1000, 32'h0);
    wait_n(2);
    chk("R11 dist off irq", 32'(irq_out), 0);
    bus_read(13'h000C, d); chk("R11 dist off ack", d, SPUR);
    bus_write(13'h1000, 32'h1);
    bus_write(13'h0000, 32'h0);
    wait_n(2);
    chk("R11 cpu off irq", 32'(irq_out), 0);
    bus_read(13'h000C, d); chk("R11 cpu off ack", d, SPUR);
    bus_write(13'h0000, 32'h1);
    wait_n(2);
    bus_read(13'h000C, d); chk("R4 model bit ack", d, 7);
    bus_write(13'h0010, 32'd7);
    wait_n(2);
    chk("R4 model bit still level", 32'(irq_out), 1);
    bus_read(13'h1C00, d); chk("R4 model bit stored", d, 32'h1 << 14);
    bus_read(13'h000C, d); chk("R4 level reack", d, 7);
    irq_in[7] = 1'b0;
    bus_write(13'h0010, 32'd7);
    wait_n(3);
    chk("R12 final idle", 32'(irq_out), 0);

    done = 1'b1;
    finish_run();
  end
endmodule